// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block produces a pulse train with a programmable period and a programmable high/low split. A 16-bit up-counter advances on ticks taken from a small prescaler. A period register sets the last count of each period. When the counter reaches that value it returns to zero and raises a one-clock interrupt. A separate split-point register marks the count at which the output flips part way through the period. The output flip-flop inverts at the split point, at the period end, or at both. Each of these two triggers has its own enable.

Software programs the block through a plain write port with four addresses. It then starts the block with a run input. A synchronous-start option holds a started timer in a waiting state until a shared start input is seen. Several instances wired to the same start input therefore begin counting on the same clock. The split-point value can be shadowed, so that a new value takes effect only at a period boundary and a half-finished period is never distorted.

Top module: `ppg_timer`

## Requirements
- R1: After reset, `pulse_out` and `cycle_irq` are 0. The control fields are all 0, the split point is 0, the period value is all ones, and the timer is stopped.
- R2: Control address 0, bits [2:1], select the tick rate: 0 gives a tick on every clock, 1 on every 4th clock and 2 or 3 on every 16th clock. Counted from the start edge, ticks fall on edges N, 2N, 3N and so on. Comparisons and counting happen only on ticks.
- R3: The counter starts at 0 and steps up by one per tick. On the tick that finds it equal to the period value (address 2), it returns to 0, so one period lasts period+1 ticks.
- R4: `cycle_irq` is high for exactly the one clock that follows each tick on which the counter wrapped.
- R5: With output control bit 0 set (address 3), `pulse_out` inverts on the tick that finds the counter equal to the split point (address 1). This happens only when the split point is less than the period value. Otherwise that trigger never fires.
- R6: With output control bit 1 set, `pulse_out` inverts on every wrap tick. The two enables are independent.
- R7: A write to address 3 with bit 2 set drives `pulse_out` to 0 on the edge that takes the write. This has priority over any inversion on the same edge.
- R8: With control bit 0 clear, a split-point write is used from the edge that takes it.
- R9: With control bit 0 set, a split-point write is held in a shadow register. It is used only from the period that follows the next wrap tick.
- R10: Taking `run` low stops ticking from the next edge, clears the counter and the prescaler, and leaves `pulse_out` unchanged. A restart counts again from 0.
- R11: With control bit 3 set, raising `run` only arms the timer. Counting begins from the edge on which `sync_start` is sampled high, and nothing on the outputs changes before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 split point, 2 period, 3 output control |
| wr_data | input | 16 | Write data |
| run | input | 1 | Run (1) / stop (0) |
| sync_start | input | 1 | Shared start for synchronous mode |
| pulse_out | output | 1 | Pulse output flip-flop |
| cycle_irq | output | 1 | One-clock pulse after each period wrap |

## Verification
Call the edge that starts counting edge 0. With a tick rate of N, tick j lands on edge j·N. Both `pulse_out` and `cycle_irq` change on that edge, because they are registered directly from the tick's comparisons. Register writes act on the edge that captures them. A forced-low write is therefore visible one clock after it is driven, and a stop takes effect on the first edge after `run` falls. The bench drives and samples on the falling edge. For every edge n after the start it predicts the irq and the output level from these formulas and compares both at that sample.

// File: rtl/ppg_pkg.sv
`timescale 1ns/1ps
package ppg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } run_state_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_SPLIT = 2'd1;
    localparam logic [1:0] ADDR_CYCLE = 2'd2;
    localparam logic [1:0] ADDR_OUT   = 2'd3;

    typedef struct packed {
        logic       sync_mode;
        logic [1:0] tick_sel;
        logic       shadowed;
    } ctrl_t;

    typedef struct packed {
        logic on_wrap;
        logic on_split;
    } toggle_t;

endpackage

// File: rtl/ppg_regs.sv
`timescale 1ns/1ps
module ppg_regs
    import ppg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         reload,
    output ctrl_t        ctrl,
    output toggle_t      tog,
    output logic [W-1:0] split_val,
    output logic [W-1:0] cycle_val,
    output logic         force_low
);

    logic [W-1:0] split_shadow;
    logic         wr_ctrl;
    logic         wr_split;
    logic         wr_cycle;
    logic         wr_out;

    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
        wr_split = wr_en && (wr_addr == ADDR_SPLIT);
        wr_cycle = wr_en && (wr_addr == ADDR_CYCLE);
        wr_out   = wr_en && (wr_addr == ADDR_OUT);
        force_low = wr_out && wr_data[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            tog  <= '0;
            cycle_val <= '1;
        end else begin
            if (wr_ctrl) begin
                ctrl.shadowed  <= wr_data[0];
                ctrl.tick_sel  <= wr_data[2:1];
                ctrl.sync_mode <= wr_data[3];
            end
            if (wr_out) begin
                tog.on_split <= wr_data[0];
                tog.on_wrap  <= wr_data[1];
            end
            if (wr_cycle) begin
                cycle_val <= wr_data;
            end
        end
    end

    // split point: shadow always follows writes; active copy follows
    // either immediately or at the wrap, depending on the shadow mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            split_shadow <= '0;
            split_val    <= '0;
        end else begin
            if (wr_split) begin
                split_shadow <= wr_data;
            end
            if (wr_split && !ctrl.shadowed) begin
                split_val <= wr_data;
            end else if (reload && ctrl.shadowed) begin
                split_val <= split_shadow;
            end
        end
    end

endmodule

// File: rtl/ppg_prescaler.sv
`timescale 1ns/1ps
module ppg_prescaler #(
    parameter int TAP_SHIFT = 2,
    parameter int NUM_TAPS  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] sel,
    output logic       tick
);

    localparam int PW = TAP_SHIFT * (NUM_TAPS - 1);

    logic [PW-1:0]       pre_q;
    logic [NUM_TAPS-1:0] tap_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (enable) begin
            pre_q <= pre_q + PW'(1);
        end else begin
            pre_q <= '0;
        end
    end

    generate
        for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
            if (k == 0) begin : g_first
                assign tap_hit[k] = 1'b1;
            end else begin : g_div
                assign tap_hit[k] = &pre_q[TAP_SHIFT*k-1:0];
            end
        end
    endgenerate

    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (int'(sel) == k || (k == NUM_TAPS - 1 && int'(sel) > k)) begin
                tick = enable && tap_hit[k];
            end
        end
    end

endmodule

// File: rtl/ppg_fsm.sv
`timescale 1ns/1ps
module ppg_fsm
    import ppg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       sync_mode,
    input  logic       sync_start,
    output run_state_e state,
    output logic       count_en
);

    run_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (run) begin
                    state_d = sync_mode ? ST_ARMED : ST_COUNT;
                end
            end
            ST_ARMED: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (sync_start) begin
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        count_en = 1'b0;
        unique case (state)
            ST_IDLE:  count_en = 1'b0;
            ST_ARMED: count_en = 1'b0;
            ST_COUNT: count_en = run;
            default:  count_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/ppg_core.sv
`timescale 1ns/1ps
module ppg_core
    import ppg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    input  logic         tick,
    input  logic [W-1:0] split_val,
    input  logic [W-1:0] cycle_val,
    input  toggle_t      tog,
    input  logic         force_low,
    output logic [W-1:0] count,
    output logic         wrap_hit,
    output logic         pulse_out,
    output logic         cycle_irq
);

    logic split_hit;
    logic flip;

    always_comb begin
        wrap_hit  = tick && (count == cycle_val);
        split_hit = tick && (count == split_val) && (split_val < cycle_val);
        flip      = (wrap_hit && tog.on_wrap) || (split_hit && tog.on_split);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!count_en || wrap_hit) begin
            count <= '0;
        end else if (tick) begin
            count <= count + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_out <= 1'b0;
            cycle_irq <= 1'b0;
        end else begin
            cycle_irq <= wrap_hit;
            if (force_low) begin
                pulse_out <= 1'b0;
            end else if (flip) begin
                pulse_out <= ~pulse_out;
            end
        end
    end

endmodule

// File: rtl/ppg_timer.sv
`timescale 1ns/1ps
module ppg_timer
    import ppg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int TAP_SHIFT = 2,
    parameter int NUM_TAPS  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             run,
    input  logic             sync_start,
    output logic             pulse_out,
    output logic             cycle_irq
);

    ctrl_t            ctrl;
    toggle_t          tog;
    logic [CNT_W-1:0] split_val;
    logic [CNT_W-1:0] cycle_val;
    logic [CNT_W-1:0] count;
    logic             force_low;
    logic             wrap_hit;
    logic             tick;
    logic             count_en;
    run_state_e       state;

    ppg_regs #(.W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .reload    (wrap_hit),
        .ctrl      (ctrl),
        .tog       (tog),
        .split_val (split_val),
        .cycle_val (cycle_val),
        .force_low (force_low)
    );

    ppg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sync_mode  (ctrl.sync_mode),
        .sync_start (sync_start),
        .state      (state),
        .count_en   (count_en)
    );

    ppg_prescaler #(.TAP_SHIFT(TAP_SHIFT), .NUM_TAPS(NUM_TAPS)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (count_en),
        .sel    (ctrl.tick_sel),
        .tick   (tick)
    );

    ppg_core #(.W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (count_en),
        .tick      (tick),
        .split_val (split_val),
        .cycle_val (cycle_val),
        .tog       (tog),
        .force_low (force_low),
        .count     (count),
        .wrap_hit  (wrap_hit),
        .pulse_out (pulse_out),
        .cycle_irq (cycle_irq)
    );

endmodule

// File: rtl/ppg_timer_chk.sv
`timescale 1ns/1ps
module ppg_timer_chk
    import ppg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             pulse_out,
    input logic             cycle_irq,
    input run_state_e       state,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cycle_val,
    input logic             tick,
    input logic             force_low
);

    assert_idle_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (count == '0));

    assert_irq_after_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_irq |-> (count == '0));

    assert_irq_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_irq |-> $past(tick));

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && state == ST_COUNT && run) |=> $stable(count));

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == cycle_val) |=> (count == '0));

    assert_no_tick_unless_counting_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COUNT) |-> !tick);

    assert_force_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        force_low |=> !pulse_out);

    assert_output_moves_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pulse_out) |-> $past(tick || force_low));

endmodule

bind ppg_timer ppg_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .pulse_out (pulse_out),
    .cycle_irq (cycle_irq),
    .state     (state),
    .count     (count),
    .cycle_val (cycle_val),
    .tick      (tick),
    .force_low (force_low)
);

// File: tb/ppg_timer_tb.sv
`timescale 1ns/1ps
module ppg_timer_tb;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        run;
    logic        sync_start;
    logic        pulse_out;
    logic        cycle_irq;

    int tests;
    int fails;
    bit done;

    ppg_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .run        (run),
        .sync_start (sync_start),
        .pulse_out  (pulse_out),
        .cycle_irq  (cycle_irq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_cfg(input int sel, input int d0, input int cyc,
                           input bit togs, input bit togw, input bit shad,
                           input bit sync, input int wr_edge, input int d1,
                           input int newp, input string req);
        int  div;
        int  ncyc;
        bit  ff_e;
        int  bad_irq;
        int  bad_ff;
        bit  held_ok;
        logic [1:0] s;
        s = sel[1:0];
        run = 1'b0;
        sync_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr(2'd0, 16'h0);
        wr(2'd1, d0[15:0]);
        wr(2'd2, cyc[15:0]);
        wr(2'd3, {13'b0, 1'b1, togw, togs});
        wr(2'd0, {12'b0, sync, s, shad});
        div = 1 << (2 * ((sel > 2) ? 2 : sel));
        ncyc = div * (cyc + 1) * 3 + 2;
        run = 1'b1;
        if (sync) begin
            held_ok = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (pulse_out !== 1'b0 || cycle_irq !== 1'b0) held_ok = 1'b0;
            end
            check(held_ok, "R11", "outputs moved while armed", int'(held_ok), 1);
            sync_start = 1'b1;
            @(negedge clk);
            sync_start = 1'b0;
        end else begin
            @(negedge clk);
        end
        // now at edge 0
        if (wr_edge == 1) begin
            wr_en = 1'b1; wr_addr = 2'd1; wr_data = d1[15:0];
        end
        ff_e = 1'b0;
        bad_irq = 0;
        bad_ff = 0;
        for (int n = 1; n <= ncyc; n++) begin
            bit tk;
            bit irq_e;
            int j;
            @(negedge clk);
            tk = (n % div) == 0;
            j = n / div;
            irq_e = tk && ((j % (cyc + 1)) == 0);
            if (tk) begin
                int p;
                int dp;
                bit tg;
                p = (j - 1) / (cyc + 1);
                dp = (wr_edge > 0 && p >= newp) ? d1 : d0;
                tg = (togw && (j % (cyc + 1)) == 0) ||
                     (togs && dp < cyc && ((j - 1) % (cyc + 1)) == dp);
                if (tg) ff_e = ~ff_e;
            end
            if (cycle_irq !== irq_e) bad_irq++;
            if (pulse_out !== ff_e) bad_ff++;
            if (n == wr_edge) wr_en = 1'b0;
            if (wr_edge > 1 && n == wr_edge - 1) begin
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = d1[15:0];
            end
        end
        wr_en = 1'b0;
        check(bad_irq == 0, req, $sformatf("irq cycles wrong sel=%0d d=%0d c=%0d", sel, d0, cyc), bad_irq, 0);
        check(bad_ff == 0, req, $sformatf("output cycles wrong sel=%0d d=%0d c=%0d", sel, d0, cyc), bad_ff, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tests = 0; fails = 0; done = 1'b0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        run = 1'b0; sync_start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(pulse_out === 1'b0, "R1", "pulse_out after reset", int'(pulse_out), 0);
        check(cycle_irq === 1'b0, "R1", "cycle_irq after reset", int'(cycle_irq), 0);

        // R2 R3 R4 R5 R6: sweep tick rates, periods and split points
        for (int sel = 0; sel < 4; sel++) begin
            for (int ci = 0; ci < 4; ci++) begin
                int cyc;
                cyc = (ci == 3) ? 4 : ci;
                for (int d = 0; d <= cyc + 1; d++) begin
                    run_cfg(sel, d, cyc, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R2_R3_R4_R5");
                end
            end
        end

        // R5: split trigger alone; R6: wrap trigger alone
        run_cfg(0, 2, 5, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R5");
        run_cfg(1, 3, 5, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R6");

        // R8: immediate split write mid period 0 (before old split point)
        run_cfg(0, 2, 7, 1'b1, 1'b0, 1'b0, 1'b0, 2, 5, 0, "R8");
        // R9: shadowed split write only used from period 1
        run_cfg(0, 2, 7, 1'b1, 1'b0, 1'b1, 1'b0, 2, 5, 1, "R9");

        // R11: synchronous start waits for sync_start
        run_cfg(0, 1, 3, 1'b1, 1'b1, 1'b0, 1'b1, 0, 0, 0, "R11");
        run_cfg(1, 0, 0, 1'b0, 1'b1, 1'b0, 1'b1, 0, 0, 0, "R11");

        // R10: stop mid run, then restart from zero
        run = 1'b1;
        repeat (5) @(negedge clk);
        run_cfg(0, 3, 7, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R10");

        // R10 hold and R7 force-low: wrap toggle each clock, stop with output high
        run = 1'b0;
        @(negedge clk);
        wr(2'd0, 16'h0);
        wr(2'd2, 16'h0);
        wr(2'd3, 16'h6);
        run = 1'b1;
        @(negedge clk);               // edge 0
        @(negedge clk);               // edge 1: output 1
        check(pulse_out === 1'b1, "R6", "output after first wrap", int'(pulse_out), 1);
        run = 1'b0;
        @(negedge clk);
        check(pulse_out === 1'b1, "R10", "output held after stop", int'(pulse_out), 1);
        check(cycle_irq === 1'b0, "R10", "irq after stop", int'(cycle_irq), 0);
        repeat (3) @(negedge clk);
        check(pulse_out === 1'b1, "R10", "output still held", int'(pulse_out), 1);
        wr(2'd3, 16'h4);
        check(pulse_out === 1'b0, "R7", "output after force low", int'(pulse_out), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule